// File: doc/BRIEF.md
# Dual Reference Divider with Routing

This block turns one reference clock into two related reference strobes for a pair of phase detectors. A common down-counter divides the reference clock by a programmable ratio of 8 to 1023. Every strobe of that counter advances a small subdivider, which divides again by 1 to 16. The subdivider strobe is issued one reference cycle after the common strobe that produced it. The two comparison instants therefore stay phase-locked to each other and never fall in the same cycle.

A routing bit decides which strobe feeds the RF detector and which feeds the IF detector. The host presents a common coefficient, a subdivider code and a routing bit, then pulses a load request. The values are held in a shadow stage. The common ratio and the routing take effect at the next common terminal count. The subdivider ratio takes effect at the next subdivider terminal count. No counter ever runs a period with a half-updated ratio.

Top module: `dual_ref_divider`

## Requirements
- R1: The common strobe is high for exactly one reference clock cycle and repeats every C cycles, where C is the active common ratio.
- R2: A common coefficient below 8 is taken as 8. Coefficients from 8 to 1023 are used as given.
- R3: The 4-bit subdivider code is a binary number with bit 0 as LSB. Code n gives a subdivider strobe every (n+1) common strobes. Code 0 gives ratio 1 and code 15 gives ratio 16.
- R4: Every subdivider strobe is high exactly one cycle after a common strobe. The two strobes are never high in the same cycle.
- R5: With the routing bit at 1, `rf_ref_stb` carries the subdivider strobe and `if_ref_stb` carries the common strobe. With the routing bit at 0, the assignment is swapped.
- R6: Coefficient, code and routing inputs are captured only on a cycle with `load_req` high. At any other time they have no effect.
- R7: After a load, the common period already running completes with the old ratio. The new common ratio and the new routing apply from the next common terminal count.
- R8: After a load, the new subdivider code applies from the next subdivider terminal count. The subdivider period already running completes with the old code.
- R9: During reset both outputs are low. After reset the common ratio is 8, the code is 0 and the routing bit is 1. The first common strobe follows the 7th rising edge after reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cdiv_coef | input | CW (10) | Common divider coefficient |
| sub_code | input | SW (4) | Subdivider code, ratio = code + 1 |
| route_sel | input | 1 | 1: subdivider to RF, common to IF; 0: swapped |
| load_req | input | 1 | Capture the three programming inputs |
| rf_ref_stb | output | 1 | Reference strobe for the RF phase detector |
| if_ref_stb | output | 1 | Reference strobe for the IF phase detector |

## Verification
The bound checker watches these properties on every cycle:
- the common strobe is one cycle wide;
- the counters stay inside their active ratios, and the common ratio never drops below 8;
- each subdivider strobe follows a common strobe by one cycle and never coincides with it, so the two outputs are never high together;
- the active ratios change only at their own terminal counts.

Only the bench scenarios show the following:
- the actual periods for each code and coefficient;
- the binary decoding of the code;
- the routing direction;
- that a load in the middle of a period lets the old period finish;
- that unloaded input changes are ignored.

// File: rtl/dual_ref_divider.sv
module dual_ref_divider #(
  parameter int CW          = 10,
  parameter int SW          = 4,
  parameter int MIN_RATIO   = 8,
  parameter int RESET_RATIO = 8,
  parameter int RESET_CODE  = 0,
  parameter bit RESET_ROUTE = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cdiv_coef,
  input  logic [SW-1:0] sub_code,
  input  logic          route_sel,
  input  logic          load_req,
  output logic          rf_ref_stb,
  output logic          if_ref_stb
);
  localparam logic [CW-1:0] MIN_C = CW'(MIN_RATIO);
  localparam logic [CW-1:0] RST_C = CW'(RESET_RATIO);
  localparam logic [SW-1:0] RST_S = SW'(RESET_CODE);

  logic [CW-1:0] cur_c, sh_c, ccnt;
  logic [SW-1:0] cur_s, sh_s, scnt;
  logic          route_q, sh_route, pend_c, pend_s, s_stb;

  wire           c_stb = (ccnt == '0);
  wire           s_tc  = c_stb && (scnt == '0);
  wire [CW-1:0] nxt_c = pend_c ? sh_c : cur_c;
  wire [SW-1:0] nxt_s = pend_s ? sh_s : cur_s;
  wire [CW-1:0] coef_clamped = (cdiv_coef < MIN_C) ? MIN_C : cdiv_coef;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_c     <= RST_C;
      sh_s     <= RST_S;
      sh_route <= RESET_ROUTE;
      pend_c   <= 1'b0;
      pend_s   <= 1'b0;
    end else if (load_req) begin
      sh_c     <= coef_clamped;
      sh_s     <= sub_code;
      sh_route <= route_sel;
      pend_c   <= 1'b1;
      pend_s   <= 1'b1;
    end else begin
      if (c_stb) pend_c <= 1'b0;
      if (s_tc)  pend_s <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccnt    <= RST_C - 1'b1;
      cur_c   <= RST_C;
      route_q <= RESET_ROUTE;
    end else if (c_stb) begin
      ccnt  <= nxt_c - 1'b1;
      cur_c <= nxt_c;
      if (pend_c) route_q <= sh_route;
    end else begin
      ccnt <= ccnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scnt  <= RST_S;
      cur_s <= RST_S;
      s_stb <= 1'b0;
    end else begin
      s_stb <= s_tc;
      if (s_tc) begin
        scnt  <= nxt_s;
        cur_s <= nxt_s;
      end else if (c_stb) begin
        scnt <= scnt - 1'b1;
      end
    end
  end

  assign rf_ref_stb = route_q ? s_stb : c_stb;
  assign if_ref_stb = route_q ? c_stb : s_stb;
endmodule

module dual_ref_divider_chk #(
  parameter int CW        = 10,
  parameter int SW        = 4,
  parameter int MIN_RATIO = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          load_req,
  input logic          c_stb,
  input logic          s_stb,
  input logic          s_tc,
  input logic          pend_c,
  input logic [CW-1:0] cur_c,
  input logic [CW-1:0] ccnt,
  input logic [SW-1:0] cur_s,
  input logic [SW-1:0] scnt,
  input logic          rf_ref_stb,
  input logic          if_ref_stb
);
  assert_min_ratio_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cur_c >= CW'(MIN_RATIO));
  assert_single_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    c_stb |=> !c_stb);
  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ccnt < cur_c);
  assert_sub_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    scnt <= cur_s);
  assert_sub_after_common_R4: assert property (@(posedge clk) disable iff (!rst_n)
    s_stb |-> $past(c_stb));
  assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(c_stb && s_stb));
  assert_outputs_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rf_ref_stb && if_ref_stb));
  assert_common_ratio_safe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !c_stb |=> $stable(cur_c));
  assert_pending_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (c_stb && !load_req) |=> !pend_c);
  assert_sub_ratio_safe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !s_tc |=> $stable(cur_s));
endmodule

bind dual_ref_divider dual_ref_divider_chk #(.CW(CW), .SW(SW), .MIN_RATIO(MIN_RATIO)) chk (
  .clk(clk), .rst_n(rst_n), .load_req(load_req), .c_stb(c_stb), .s_stb(s_stb),
  .s_tc(s_tc), .pend_c(pend_c), .cur_c(cur_c), .ccnt(ccnt), .cur_s(cur_s),
  .scnt(scnt), .rf_ref_stb(rf_ref_stb), .if_ref_stb(if_ref_stb)
);

// File: tb/dual_ref_divider_test.sv
`timescale 1ns/1ps
module dual_ref_divider_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] cdiv_coef = '0;
  logic [3:0] sub_code = '0;
  logic       route_sel = 1'b1;
  logic       load_req = 1'b0;
  logic       rf_ref_stb, if_ref_stb;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  int cur_cfg_c = 8;

  dual_ref_divider uut (
    .clk(clk), .rst_n(rst_n), .cdiv_coef(cdiv_coef), .sub_code(sub_code),
    .route_sel(route_sel), .load_req(load_req),
    .rf_ref_stb(rf_ref_stb), .if_ref_stb(if_ref_stb)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 190000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: act=%0d exp<%0d", cycles, 190000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic bit pin(input bit sel);
    return sel ? if_ref_stb : rf_ref_stb;
  endfunction

  task automatic wait_pin(input bit sel, output int cyc);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!pin(sel) && cyc < 40000);
  endtask

  task automatic do_load(input int c, input int s, input bit r);
    cdiv_coef = 10'(c);
    sub_code  = 4'(s);
    route_sel = r;
    load_req  = 1'b1;
    @(negedge clk);
    load_req  = 1'b0;
  endtask

  task automatic measure(input int craw, input int s, input bit r, input string creq);
    int  expc, cyc, ncomm;
    bit  subsel, comsel, lastc, c, sb;
    expc   = (craw < 8) ? 8 : craw;
    subsel = r ? 1'b0 : 1'b1;
    comsel = ~subsel;
    wait_pin(subsel, cyc);
    cyc = 0; ncomm = 0; lastc = 1'b0; c = 1'b0; sb = 1'b0;
    do begin
      lastc = c;
      @(negedge clk);
      cyc++;
      c  = pin(comsel);
      sb = pin(subsel);
      if (c) ncomm++;
    end while (!sb && cyc < 40000);
    check(cyc == expc * (s + 1), "R3 sub period", cyc, expc * (s + 1));
    check(ncomm == s + 1, "R3 common strobes per sub", ncomm, s + 1);
    check(lastc && !c, "R4 sub one cycle after common", {lastc, c}, 2);
    wait_pin(comsel, cyc);
    wait_pin(comsel, cyc);
    check(cyc == expc, {creq, " common period"}, cyc, expc);
    @(negedge clk);
    check(!pin(comsel), "R1 single-cycle pulse", pin(comsel), 0);
  endtask

  task automatic program_and_measure(input int c, input int s, input bit r, input string creq);
    int eff;
    eff = (c < 8) ? 8 : c;
    do_load(c, s, r);
    repeat (cur_cfg_c + 16 * eff + 4) @(negedge clk);
    cur_cfg_c = eff;
    measure(c, s, r, creq);
  endtask

  initial begin
    int cyc, tot;
    repeat (4) @(negedge clk);
    check(!rf_ref_stb && !if_ref_stb, "R9 outputs low in reset", {rf_ref_stb, if_ref_stb}, 0);
    rst_n = 1'b1;
    wait_pin(1'b1, cyc);
    check(cyc == 7, "R9 first common strobe", cyc, 7);
    @(negedge clk);
    check(rf_ref_stb && !if_ref_stb, "R9 reset code 0 route 1 on RF", {rf_ref_stb, if_ref_stb}, 2);
    measure(8, 0, 1'b1, "R1");

    for (int s = 0; s < 16; s++)
      program_and_measure(8, s, s[1], "R1");

    program_and_measure(9, 5, 1'b0, "R1");
    program_and_measure(13, 2, 1'b1, "R1");
    program_and_measure(0, 3, 1'b1, "R2");
    program_and_measure(7, 1, 1'b0, "R2");
    program_and_measure(255, 15, 1'b1, "R2");
    program_and_measure(1023, 1, 1'b0, "R2");
    program_and_measure(8, 0, 1'b0, "R5");
    program_and_measure(8, 0, 1'b1, "R5");

    program_and_measure(11, 2, 1'b1, "R1");
    cdiv_coef = 10'd30; sub_code = 4'd9; route_sel = 1'b0;
    repeat (300) @(negedge clk);
    measure(11, 2, 1'b1, "R6");

    program_and_measure(12, 2, 1'b1, "R1");
    wait_pin(1'b1, cyc);
    tot = 0;
    repeat (2) begin
      @(negedge clk); tot++;
    end
    do_load(20, 2, 1'b1); tot++;
    wait_pin(1'b1, cyc);
    tot += cyc;
    check(tot == 12, "R7 running period keeps old ratio", tot, 12);
    wait_pin(1'b1, cyc);
    check(cyc == 20, "R7 new ratio at next terminal count", cyc, 20);
    cur_cfg_c = 20;

    program_and_measure(10, 3, 1'b1, "R1");
    wait_pin(1'b0, cyc);
    do_load(10, 1, 1'b1);
    tot = 1;
    wait_pin(1'b0, cyc);
    tot += cyc;
    check(tot == 40, "R8 running sub period keeps old code", tot, 40);
    wait_pin(1'b0, cyc);
    check(cyc == 20, "R8 new code at next sub terminal count", cyc, 20);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule